// File: doc/BRIEF.md
# 64-bit Atomic Compare-Exchange Unit

This block performs one 8-byte compare-and-exchange on a memory word. A start pulse captures four inputs: a word address, a 64-bit expected value given as high and low 32-bit halves, a 64-bit replacement value in the same two-half form, and the current arithmetic flag vector. The block then reads the addressed word through a simple request/acknowledge memory port and compares all 64 bits against the expected value in a single cycle.

On a match, the block writes the replacement value back to the same address. On a mismatch, it issues no write. In both cases the word that was read comes back on the result pair, so a mismatch hands the caller the fresh memory value as its next expected value. The zero flag reports the outcome and the other five flags pass through unchanged.

A lock output stays high for the whole read-check-write window, so the memory system can keep other masters away from the word. Address generation, decode, caching and faults are handled elsewhere.

Top module: `cas64_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, busy, done, mem_req and mem_lock are low, and res_hi, res_lo and flags_out are zero.
- R2: A start taken while idle produces one read request (mem_req high, mem_we low) for the captured address. The request is held until mem_ack, and mem_rdata is taken in the acknowledge cycle.
- R3: If the word read equals {cmp_hi,cmp_lo}, exactly one write of {xchg_hi,xchg_lo} to the same address follows. The result pair then shows the word read, which equals the expected value.
- R4: If the word read differs from {cmp_hi,cmp_lo}, no write request is made and memory keeps its value. {res_hi,res_lo} returns the word read.
- R5: flags_out bit 3 (zero) is 1 after a match and 0 after a mismatch, whatever flags_in bit 3 was.
- R6: flags_out bits 0 (carry), 1 (parity), 2 (auxiliary carry), 4 (sign) and 5 (overflow) equal the flags_in bits captured with start.
- R7: mem_lock is high whenever mem_req is high. It stays high from the first read-request cycle through the write acknowledge on a match, or through the compare cycle on a mismatch, and it is low in the done cycle.
- R8: A start that arrives while busy is high (done cycle included) is ignored. It causes no memory request and changes no memory word, and mem_addr stays constant through an operation.
- R9: Suppose the memory acknowledges each request after L wait cycles. Counting from the clock edge that samples start, done is high for exactly one cycle, in cycle 2L+4 on a match and in cycle L+3 on a mismatch. With L=0 this stays inside the 10-cycle budget.
- R10: A difference in any single bit of the 64, including bit 0 of the low half and bit 31 of the high half, counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| addr | input | ADDR_W | Word address of the target |
| cmp_hi | input | HALF_W | Expected value, upper half |
| cmp_lo | input | HALF_W | Expected value, lower half |
| xchg_hi | input | HALF_W | Replacement value, upper half |
| xchg_lo | input | HALF_W | Replacement value, lower half |
| flags_in | input | 6 | Flag vector: 0 carry, 1 parity, 2 aux carry, 3 zero, 4 sign, 5 overflow |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | HALF_W | Word read, upper half |
| res_lo | output | HALF_W | Word read, lower half |
| flags_out | output | 6 | Flags with the zero bit replaced by the compare outcome |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Bus lock across the atomic window |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 2*HALF_W | Write data |
| mem_ack | input | 1 | Request accepted (read data valid) |
| mem_rdata | input | 2*HALF_W | Read data |

## Verification
The bench builds the unit with HALF_W=32, ADDR_W=8 and CMP_CHUNK=16. This selects the chunked comparator variant, a four-slice equality tree, rather than the single wide compare. A memory model with a random wait of 0 to 2 cycles exposes the 2L+4 and L+3 completion timing and keeps the lock window open across stretched requests. The narrow address maps onto a 16-word model, so a stray start aimed at a neighbouring word would leave a visible write.

// File: rtl/cas64_pkg.sv
package cas64_pkg;
   localparam int FLAG_W    = 6;
   localparam int FLG_CARRY = 0;
   localparam int FLG_PAR   = 1;
   localparam int FLG_AUX   = 2;
   localparam int FLG_ZERO  = 3;
   localparam int FLG_SIGN  = 4;
   localparam int FLG_OVF   = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_CHECK,
      ST_WRITE,
      ST_DONE
   } cas_state_e;
endpackage

// File: rtl/cas64_compare.sv
module cas64_compare #(
   parameter int DATA_W  = 64,
   parameter int CHUNK_W = 64
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic              equal
);
   localparam int NCHUNK = (CHUNK_W >= DATA_W) ? 1 : DATA_W / CHUNK_W;

   if (CHUNK_W < 1) begin : g_bad_chunk
      $error("cas64_compare: CHUNK_W must be positive");
   end
   if (CHUNK_W < DATA_W && (DATA_W % CHUNK_W) != 0) begin : g_bad_split
      $error("cas64_compare: CHUNK_W must divide DATA_W");
   end

   if (NCHUNK == 1) begin : g_flat
      assign equal = (lhs == rhs);
   end else begin : g_tree
      logic [NCHUNK-1:0] slice_eq;
      for (genvar i = 0; i < NCHUNK; i++) begin : g_slice
         assign slice_eq[i] = (lhs[i*CHUNK_W +: CHUNK_W] == rhs[i*CHUNK_W +: CHUNK_W]);
      end
      assign equal = &slice_eq;
   end
endmodule

// File: rtl/cas64_seq.sv
module cas64_seq
   import cas64_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] expect_v,
   input  logic [DATA_W-1:0] repl_v,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic              match,
   output logic [DATA_W-1:0] expect_q,
   output logic [DATA_W-1:0] rdat_q,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags_out,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   cas_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] repl_q;
   logic [FLAG_W-1:0] flg_q;
   logic              hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr_q    <= '0;
         expect_q  <= '0;
         repl_q    <= '0;
         flg_q     <= '0;
         rdat_q    <= '0;
         hit_q     <= 1'b0;
         result    <= '0;
         flags_out <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               addr_q   <= addr;
               expect_q <= expect_v;
               repl_q   <= repl_v;
               flg_q    <= flags_in;
               state    <= ST_READ;
            end
            ST_READ: if (mem_ack) begin
               rdat_q <= mem_rdata;
               state  <= ST_CHECK;
            end
            ST_CHECK: begin
               hit_q               <= match;
               result              <= rdat_q;
               flags_out           <= flg_q;
               flags_out[FLG_ZERO] <= match;
               state               <= match ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: if (mem_ack) state <= ST_DONE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state == ST_READ) || (state == ST_WRITE);
      mem_we    = (state == ST_WRITE);
      mem_lock  = (state == ST_READ) || (state == ST_CHECK) || (state == ST_WRITE);
      busy      = (state != ST_IDLE);
      done      = (state == ST_DONE);
      mem_addr  = addr_q;
      mem_wdata = repl_q;
   end

   // R7: no request ever leaves the unit without the lock held
   a_r7_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lock);
   // R4: a write request may only follow a successful compare
   a_r4_write_only_hit: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> hit_q);
   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: the target address cannot move mid-operation
   a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr));
   // R7: lock released when done reports
   a_r7_unlock_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!mem_lock && $fell(mem_lock)));
endmodule

// File: rtl/cas64_unit.sv
module cas64_unit
   import cas64_pkg::*;
#(
   parameter int HALF_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int CMP_CHUNK = 2 * HALF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [HALF_W-1:0]   cmp_hi,
   input  logic [HALF_W-1:0]   cmp_lo,
   input  logic [HALF_W-1:0]   xchg_hi,
   input  logic [HALF_W-1:0]   xchg_lo,
   input  logic [FLAG_W-1:0]   flags_in,
   output logic                busy,
   output logic                done,
   output logic [HALF_W-1:0]   res_hi,
   output logic [HALF_W-1:0]   res_lo,
   output logic [FLAG_W-1:0]   flags_out,
   output logic                mem_req,
   output logic                mem_we,
   output logic                mem_lock,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [2*HALF_W-1:0] mem_wdata,
   input  logic                mem_ack,
   input  logic [2*HALF_W-1:0] mem_rdata
);
   localparam int DATA_W = 2 * HALF_W;

   if (HALF_W < 8) begin : g_bad_half
      $error("cas64_unit: HALF_W below 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("cas64_unit: ADDR_W must be positive");
   end

   logic [DATA_W-1:0] expect_q;
   logic [DATA_W-1:0] rdat_q;
   logic [DATA_W-1:0] result;
   logic              match;

   cas64_compare #(
      .DATA_W  (DATA_W),
      .CHUNK_W (CMP_CHUNK)
   ) u_cmp (
      .lhs   (rdat_q),
      .rhs   (expect_q),
      .equal (match)
   );

   cas64_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .addr      (addr),
      .expect_v  ({cmp_hi, cmp_lo}),
      .repl_v    ({xchg_hi, xchg_lo}),
      .flags_in  (flags_in),
      .match     (match),
      .expect_q  (expect_q),
      .rdat_q    (rdat_q),
      .busy      (busy),
      .done      (done),
      .result    (result),
      .flags_out (flags_out),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_lock  (mem_lock),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   assign res_hi = result[DATA_W-1:HALF_W];
   assign res_lo = result[HALF_W-1:0];

   // R5: zero flag at completion agrees with result vs. captured expectation
   a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_out[FLG_ZERO] == ({res_hi, res_lo} == expect_q)));
endmodule

// File: tb/tb_cas64_unit.sv
module tb_cas64_unit;
   localparam int HALF_W = 32;
   localparam int ADDR_W = 8;
   localparam int DW     = 2 * HALF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [HALF_W-1:0] cmp_hi = '0, cmp_lo = '0, xchg_hi = '0, xchg_lo = '0;
   logic [5:0] flags_in = '0;
   logic busy, done, mem_req, mem_we, mem_lock;
   logic [HALF_W-1:0] res_hi, res_lo;
   logic [5:0] flags_out;
   logic [ADDR_W-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   always #10 clk = ~clk;

   cas64_unit #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .CMP_CHUNK(16)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
      .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .xchg_hi(xchg_hi), .xchg_lo(xchg_lo),
      .flags_in(flags_in), .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
      .flags_out(flags_out), .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   logic [DW-1:0] mem [16];
   int lat = 0;
   int wcnt = 0;
   int writes = 0;
   int reads = 0;
   int lock_bad = 0;
   int nchk = 0;
   int nfail = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
         end else if (mem_req) begin
            if (!mem_lock) lock_bad <= lock_bad + 1;
            if (wcnt == lat) begin
               mem_ack <= 1'b1;
               if (mem_we) begin
                  mem[mem_addr[3:0]] <= mem_wdata;
                  writes <= writes + 1;
               end else begin
                  mem_rdata <= mem[mem_addr[3:0]];
                  reads <= reads + 1;
               end
            end else wcnt <= wcnt + 1;
         end
      end
   end

   function automatic logic [5:0] exp_flags(input logic [5:0] f, input bit eq);
      logic [5:0] r;
      r = f;
      r[3] = eq;
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] idx, input logic [63:0] cmpv, input logic [63:0] newv,
                         input logic [5:0] fl, input int l, input bit poke);
      logic [63:0] old, nb_old;
      logic [3:0] nb;
      bit eq;
      int cyc, w0, r0, lb0, expc, quiet;
      nb = idx ^ 4'h1;
      old = mem[idx];
      nb_old = mem[nb];
      eq = (old == cmpv);
      w0 = writes; r0 = reads; lb0 = lock_bad;
      expc = eq ? 2 * l + 4 : l + 3;
      @(negedge clk);
      lat = l;
      start = 1'b1; addr = {4'h0, idx};
      {cmp_hi, cmp_lo} = cmpv; {xchg_hi, xchg_lo} = newv; flags_in = fl;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 100) begin
         if (poke && cyc == 1) begin
            start = 1'b1; addr = {4'h0, nb};
            {cmp_hi, cmp_lo} = nb_old; {xchg_hi, xchg_lo} = ~nb_old;
         end else start = 1'b0;
         @(posedge clk); @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(cyc == expc, "R9 done cycle", 64'(cyc), 64'(expc));
      chk({res_hi, res_lo} == old, eq ? "R3 result on match" : "R4 result on mismatch", {res_hi, res_lo}, old);
      chk(flags_out[3] == eq, "R5 zero flag", 64'(flags_out), 64'(exp_flags(fl, eq)));
      chk(flags_out == exp_flags(fl, eq), "R6 other flags", 64'(flags_out), 64'(exp_flags(fl, eq)));
      chk(mem[idx] == (eq ? newv : old), eq ? "R3 memory written" : "R4 memory kept", mem[idx], eq ? newv : old);
      chk((writes - w0) == (eq ? 1 : 0), "R3/R4 write count", 64'(writes - w0), 64'(eq));
      chk((reads - r0) == 1, "R2 single read", 64'(reads - r0), 64'd1);
      chk(lock_bad == lb0 && !mem_lock, "R7 lock window", 64'(lock_bad - lb0), 64'd0);
      if (poke) begin
         // start again during the done cycle; also must be ignored
         start = 1'b1; addr = {4'h0, nb};
         @(posedge clk); @(negedge clk);
         start = 1'b0;
         chk(!done, "R9 done single pulse", 64'(done), 64'd0);
         quiet = 0;
         for (int k = 0; k < 3; k++) begin
            if (mem_req || busy) quiet++;
            @(posedge clk); @(negedge clk);
         end
         chk(quiet == 0, "R8 no request after ignored start", 64'(quiet), 64'd0);
         chk(mem[nb] == nb_old, "R8 neighbour word untouched", mem[nb], nb_old);
      end else begin
         @(posedge clk); @(negedge clk);
         chk(!done, "R9 done single pulse", 64'(done), 64'd0);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !mem_lock, "R1 control outputs in reset",
          64'({busy, done, mem_req, mem_lock}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({res_hi, res_lo} == 64'd0 && flags_out == 6'd0, "R1 result outputs after reset",
          {res_hi, res_lo}, 64'd0);
      chk(!busy && !mem_req, "R1 idle after reset", 64'({busy, mem_req}), 64'd0);

      mem[5] = '1;
      run_op(4'd5, '1, 64'h0123_4567_89ab_cdef, 6'b110111, 0, 1'b0);   // R3 R5 R6 R9
      run_op(4'd6, ~mem[6], 64'h1, 6'b001000, 0, 1'b0);                  // R4 R5 R9
      run_op(4'd2, mem[2] ^ 64'h1, 64'h2, 6'b101010, 1, 1'b0);           // R10 bit 0
      run_op(4'd3, mem[3] ^ (64'h1 << 63), 64'h3, 6'b010101, 2, 1'b0);   // R10 bit 63
      run_op(4'd8, mem[8], 64'hdead_beef_0000_0001, 6'b000000, 2, 1'b1); // R8 R3
      run_op(4'd9, ~mem[9], 64'h4, 6'b111111, 1, 1'b1);                  // R8 R4

      for (int n = 0; n < 40; n++) begin
         logic [3:0] ix;
         logic [63:0] cv;
         ix = 4'($urandom % 16);
         cv = ($urandom % 2 == 0) ? mem[ix] : {$urandom, $urandom};
         run_op(ix, cv, {$urandom, $urandom}, 6'($urandom), int'($urandom % 3), ($urandom % 5) == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule